// File: doc/BRIEF.md
# System Management Mode Entry and Resume Sequencer

This block steps a simple processor core into and out of system management mode (SMM) when an I/O instruction is trapped. A management interrupt request moves it into SMM. On entry it captures a small state-save file: a trap status word, a software-writable restart slot, the interrupt-enable flag and two debug status and control values. While the core is in SMM, maskable and non-maskable interrupts are held off. Any non-maskable interrupt or further management request that arrives in that time is kept pending.

The management handler reaches the save file through a simple address, data and write-enable port. The trap status word sits at offset FFA4h and the restart slot at offset FF00h. When the handler issues the resume strobe, the block chooses between two actions. It either asks the core to re-execute the trapped I/O instruction or to continue with the next instruction. It also restores the saved flag and debug values. A debug breakpoint that coincides with the trap is deferred until after SMM ends, and past the re-executed I/O instruction when a restart was requested.

Top module: `sysmgmt_seq`

## Requirements
- R1: `smi_i` sampled while outside SMM raises `in_smm_o` and `nmi_mask_o` one cycle later. In that same cycle `eflags_we_o` pulses with `eflags_if_o` = 0.
- R2: On a first-level entry, the trap word at FFA4h reads bit 0 = `io_trap_i` and bit 1 = `io_trap_i` AND `io_valid_i`, sampled in the entry cycle. All other bits read 0.
- R3: Every entry clears the 16-bit restart slot at FF00h, which reads zero-extended to 32 bits. While in SMM, `sa_we_i` writes FFA4h (all 32 bits) or FF00h (bits 15:0). Writes made outside SMM leave both locations unchanged. Reads are combinational at any time, and any other address reads 0.
- R4: A resume strobe in SMM with slot = 00FFh and trap-word bit 1 set pulses `restart_io_o` one cycle later. In every other case it pulses `next_insn_o`.
- R5: A resume with slot = 00FFh but trap-word bit 1 clear pulses `undef_restart_o` together with `next_insn_o`.
- R6: A `smi_i` seen while in SMM is held. After the resume cycle, SMM is re-entered one cycle later, and that nested entry reads trap-word bit 1 as 0 even for a valid trap.
- R7: `dbg_bp_i` seen at entry or inside SMM produces no `dbg_trap_o` while in SMM. If the resume does not restart, `dbg_trap_o` pulses together with `next_insn_o`. Outside SMM, `dbg_bp_i` gives `dbg_trap_o` one cycle later.
- R8: If the resume restarts, a pending debug trap is raised only one cycle after `io_done_i`, the completion of the re-executed instruction.
- R9: An `nmi_i` seen in SMM is held, and `nmi_o` pulses two cycles after the resume strobe is sampled, one cycle after resume completes. Outside SMM, `nmi_i` gives `nmi_o` one cycle later.
- R10: `dr6_i` and `dr7_i` are captured at entry. At resume, `dr_we_o` pulses with `dr6_o` and `dr7_o` holding the captured values, and `eflags_we_o` pulses with `eflags_if_o` equal to the `if_i` captured at entry.
- R11: `in_smm_o` stays high from entry until the resume completes. A resume strobe outside SMM does nothing.
- R12: After reset, all outputs are 0 and both save-file locations read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smi_i | input | 1 | Management interrupt request |
| io_trap_i | input | 1 | Current instruction is a trapped I/O access |
| io_valid_i | input | 1 | Trapped I/O instruction is restartable |
| dbg_bp_i | input | 1 | Debug breakpoint trap |
| io_done_i | input | 1 | Re-executed I/O instruction completed |
| nmi_i | input | 1 | Non-maskable interrupt |
| rsm_i | input | 1 | Resume strobe from handler |
| if_i | input | 1 | Core interrupt-enable flag |
| dr6_i | input | DR_W | Debug status value from core |
| dr7_i | input | DR_W | Debug control value from core |
| sa_we_i | input | 1 | Save-file write enable |
| sa_addr_i | input | 16 | Save-file offset |
| sa_wdata_i | input | DW | Save-file write data |
| sa_rdata_o | output | DW | Save-file read data |
| in_smm_o | output | 1 | Core is in management mode |
| nmi_mask_o | output | 1 | NMI masked |
| eflags_we_o | output | 1 | Write interrupt-enable flag |
| eflags_if_o | output | 1 | Value for interrupt-enable flag |
| dr_we_o | output | 1 | Restore debug status and control |
| dr6_o | output | DR_W | Saved debug status |
| dr7_o | output | DR_W | Saved debug control |
| restart_io_o | output | 1 | Re-execute trapped I/O instruction |
| next_insn_o | output | 1 | Continue with next instruction |
| undef_restart_o | output | 1 | Restart asked for an invalid trap |
| nmi_o | output | 1 | NMI delivered to core |
| dbg_trap_o | output | 1 | Debug trap delivered to core |

## Verification
A corrupted validity bit or restart slot is visible at the handler read port straight after entry. It also shows one cycle after the resume strobe as the wrong choice among the restart, next-instruction and undefined-restart pulses. A lost or stuck pending flag for NMI, debug or a nested request shows within one or two cycles of resume: a pulse goes missing, arrives early or lands during SMM. The bench sweeps every mix of trap, validity, breakpoint, flag, NMI and four slot values, and computes each expected pulse from the requirement formulas.

// File: rtl/sysmgmt_pkg.sv
package sysmgmt_pkg;
  localparam int unsigned SA_AW = 16;
  localparam logic [SA_AW-1:0] OFS_TRAP = 16'hFFA4;
  localparam logic [SA_AW-1:0] OFS_SLOT = 16'hFF00;
  localparam logic [15:0] SLOT_RESTART = 16'h00FF;
  localparam int unsigned TRAP_BIT  = 0;
  localparam int unsigned VALID_BIT = 1;
endpackage

// File: rtl/sysmgmt_save.sv
module sysmgmt_save
  import sysmgmt_pkg::*;
#(
  parameter int unsigned DR_W = 32,
  parameter int unsigned DW   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic             nested_i,
  input  logic             io_trap_i,
  input  logic             io_valid_i,
  input  logic             if_i,
  input  logic [DR_W-1:0]  dr6_i,
  input  logic [DR_W-1:0]  dr7_i,
  input  logic             wr_en_i,
  input  logic [SA_AW-1:0] addr_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             valid_o,
  output logic             restart_o,
  output logic             saved_if_o,
  output logic [DR_W-1:0]  dr6_o,
  output logic [DR_W-1:0]  dr7_o
);
  localparam int unsigned SLOT_W = 16;

  logic [DW-1:0]     trap_dw_q, entry_dw;
  logic [SLOT_W-1:0] slot_q;
  logic              sif_q;
  logic [DR_W-1:0]   dr6_q, dr7_q;

  always_comb begin
    entry_dw            = '0;
    entry_dw[TRAP_BIT]  = io_trap_i;
    entry_dw[VALID_BIT] = io_trap_i && io_valid_i && !nested_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_dw_q <= '0;
      slot_q    <= '0;
      sif_q     <= 1'b0;
      dr6_q     <= '0;
      dr7_q     <= '0;
    end else if (entry_i) begin
      trap_dw_q <= entry_dw;
      slot_q    <= '0;
      sif_q     <= if_i;
      dr6_q     <= dr6_i;
      dr7_q     <= dr7_i;
    end else if (wr_en_i) begin
      if (addr_i == OFS_TRAP) trap_dw_q <= wdata_i;
      if (addr_i == OFS_SLOT) slot_q    <= wdata_i[SLOT_W-1:0];
    end
  end

  always_comb begin
    case (addr_i)
      OFS_TRAP: rdata_o = trap_dw_q;
      OFS_SLOT: rdata_o = DW'(slot_q);
      default:  rdata_o = '0;
    endcase
  end

  assign valid_o    = trap_dw_q[VALID_BIT];
  assign restart_o  = (slot_q == SLOT_RESTART);
  assign saved_if_o = sif_q;
  assign dr6_o      = dr6_q;
  assign dr7_o      = dr7_q;

  p_slot_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(entry_i) |-> slot_q == '0);
  p_nested_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(entry_i && nested_i) |-> !trap_dw_q[VALID_BIT]);
  p_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(entry_i && !io_trap_i) |-> !trap_dw_q[VALID_BIT]);
endmodule

// File: rtl/sysmgmt_ctrl.sv
module sysmgmt_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smi_i,
  input  logic rsm_i,
  input  logic nmi_i,
  input  logic dbg_bp_i,
  input  logic io_done_i,
  input  logic valid_i,
  input  logic restart_req_i,
  output logic in_smm_o,
  output logic entry_o,
  output logic nested_o,
  output logic eflags_we_o,
  output logic dr_we_o,
  output logic restart_io_o,
  output logic next_insn_o,
  output logic undef_o,
  output logic nmi_o,
  output logic dbg_trap_o
);
  logic in_smm_q, smi_pend_q, nmi_pend_q, dbg_pend_q, io_wait_q;
  logic eflags_we_q, dr_we_q, restart_q, next_q, undef_q, nmi_q, dbg_trap_q;
  logic entry, resume, do_restart;

  assign entry      = !in_smm_q && (smi_i || smi_pend_q);
  assign resume     = in_smm_q && rsm_i;
  assign do_restart = restart_req_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_smm_q    <= 1'b0;
      smi_pend_q  <= 1'b0;
      nmi_pend_q  <= 1'b0;
      dbg_pend_q  <= 1'b0;
      io_wait_q   <= 1'b0;
      eflags_we_q <= 1'b0;
      dr_we_q     <= 1'b0;
      restart_q   <= 1'b0;
      next_q      <= 1'b0;
      undef_q     <= 1'b0;
      nmi_q       <= 1'b0;
      dbg_trap_q  <= 1'b0;
    end else begin
      eflags_we_q <= 1'b0;
      dr_we_q     <= 1'b0;
      restart_q   <= 1'b0;
      next_q      <= 1'b0;
      undef_q     <= 1'b0;
      nmi_q       <= 1'b0;
      dbg_trap_q  <= dbg_bp_i && !in_smm_q && !entry;
      if (entry) begin
        in_smm_q    <= 1'b1;
        smi_pend_q  <= 1'b0;
        eflags_we_q <= 1'b1;
        io_wait_q   <= 1'b0;
      end
      if (in_smm_q && smi_i) smi_pend_q <= 1'b1;
      if (dbg_bp_i && (entry || (in_smm_q && !rsm_i))) dbg_pend_q <= 1'b1;
      if (resume) begin
        in_smm_q    <= 1'b0;
        eflags_we_q <= 1'b1;
        dr_we_q     <= 1'b1;
        restart_q   <= do_restart;
        next_q      <= !do_restart;
        undef_q     <= restart_req_i && !valid_i;
        if (dbg_pend_q) begin
          if (do_restart) io_wait_q <= 1'b1;
          else begin
            dbg_trap_q <= 1'b1;
            dbg_pend_q <= 1'b0;
          end
        end
      end
      // deferred trap waits for the re-executed access
      if (io_wait_q && !in_smm_q && !entry && io_done_i) begin
        dbg_trap_q <= 1'b1;
        dbg_pend_q <= 1'b0;
        io_wait_q  <= 1'b0;
      end
      if (nmi_i && (in_smm_q || entry)) nmi_pend_q <= 1'b1;
      else if (!in_smm_q && !entry) begin
        nmi_q      <= nmi_i || nmi_pend_q;
        nmi_pend_q <= 1'b0;
      end
    end
  end

  assign in_smm_o     = in_smm_q;
  assign entry_o      = entry;
  assign nested_o     = smi_pend_q;
  assign eflags_we_o  = eflags_we_q;
  assign dr_we_o      = dr_we_q;
  assign restart_io_o = restart_q;
  assign next_insn_o  = next_q;
  assign undef_o      = undef_q;
  assign nmi_o        = nmi_q;
  assign dbg_trap_o   = dbg_trap_q;

  p_entry_if_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_smm_q) |-> eflags_we_q);
  p_resume_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_smm_q) |-> (restart_q ^ next_q) && dr_we_q);
  p_undef_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_q |-> next_q);
  p_nmi_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_q |-> !nmi_q);
  p_dbg_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_smm_q |-> !dbg_trap_q);
  p_restart_defer_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |-> !dbg_trap_q);
endmodule

// File: rtl/sysmgmt_seq.sv
module sysmgmt_seq
  import sysmgmt_pkg::*;
#(
  parameter int unsigned DR_W = 32,
  parameter int unsigned DW   = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smi_i,
  input  logic             io_trap_i,
  input  logic             io_valid_i,
  input  logic             dbg_bp_i,
  input  logic             io_done_i,
  input  logic             nmi_i,
  input  logic             rsm_i,
  input  logic             if_i,
  input  logic [DR_W-1:0]  dr6_i,
  input  logic [DR_W-1:0]  dr7_i,
  input  logic             sa_we_i,
  input  logic [SA_AW-1:0] sa_addr_i,
  input  logic [DW-1:0]    sa_wdata_i,
  output logic [DW-1:0]    sa_rdata_o,
  output logic             in_smm_o,
  output logic             nmi_mask_o,
  output logic             eflags_we_o,
  output logic             eflags_if_o,
  output logic             dr_we_o,
  output logic [DR_W-1:0]  dr6_o,
  output logic [DR_W-1:0]  dr7_o,
  output logic             restart_io_o,
  output logic             next_insn_o,
  output logic             undef_restart_o,
  output logic             nmi_o,
  output logic             dbg_trap_o
);
  logic entry, nested, valid, restart_req, saved_if, in_smm;

  sysmgmt_ctrl i_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .smi_i         (smi_i),
    .rsm_i         (rsm_i),
    .nmi_i         (nmi_i),
    .dbg_bp_i      (dbg_bp_i),
    .io_done_i     (io_done_i),
    .valid_i       (valid),
    .restart_req_i (restart_req),
    .in_smm_o      (in_smm),
    .entry_o       (entry),
    .nested_o      (nested),
    .eflags_we_o   (eflags_we_o),
    .dr_we_o       (dr_we_o),
    .restart_io_o  (restart_io_o),
    .next_insn_o   (next_insn_o),
    .undef_o       (undef_restart_o),
    .nmi_o         (nmi_o),
    .dbg_trap_o    (dbg_trap_o)
  );

  sysmgmt_save #(.DR_W(DR_W), .DW(DW)) i_save (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .entry_i    (entry),
    .nested_i   (nested),
    .io_trap_i  (io_trap_i),
    .io_valid_i (io_valid_i),
    .if_i       (if_i),
    .dr6_i      (dr6_i),
    .dr7_i      (dr7_i),
    .wr_en_i    (sa_we_i && in_smm && !rsm_i),
    .addr_i     (sa_addr_i),
    .wdata_i    (sa_wdata_i),
    .rdata_o    (sa_rdata_o),
    .valid_o    (valid),
    .restart_o  (restart_req),
    .saved_if_o (saved_if),
    .dr6_o      (dr6_o),
    .dr7_o      (dr7_o)
  );

  assign in_smm_o    = in_smm;
  assign nmi_mask_o  = in_smm;
  assign eflags_if_o = in_smm ? 1'b0 : saved_if;
endmodule

// File: tb/test_sysmgmt_seq.sv
`timescale 1ns/1ps
module test_sysmgmt_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic smi = 0, io_trap = 0, io_valid = 0, dbg = 0, io_done = 0, nmi = 0, rsm = 0, ifl = 0;
  logic [31:0] dr6 = 0, dr7 = 0, wdata = 0, rdata;
  logic sa_we = 0;
  logic [15:0] sa_addr = 0;
  logic in_smm, nmi_mask, ef_we, ef_if, dr_we, restart_io, next_insn, undef, nmi_out, dbg_trap;
  logic [31:0] dr6_out, dr7_out;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sysmgmt_seq i_sysmgmt_seq (
    .clk_i(clk), .rst_ni(rst_n), .smi_i(smi), .io_trap_i(io_trap), .io_valid_i(io_valid),
    .dbg_bp_i(dbg), .io_done_i(io_done), .nmi_i(nmi), .rsm_i(rsm), .if_i(ifl),
    .dr6_i(dr6), .dr7_i(dr7), .sa_we_i(sa_we), .sa_addr_i(sa_addr), .sa_wdata_i(wdata),
    .sa_rdata_o(rdata), .in_smm_o(in_smm), .nmi_mask_o(nmi_mask), .eflags_we_o(ef_we),
    .eflags_if_o(ef_if), .dr_we_o(dr_we), .dr6_o(dr6_out), .dr7_o(dr7_out),
    .restart_io_o(restart_io), .next_insn_o(next_insn), .undef_restart_o(undef),
    .nmi_o(nmi_out), .dbg_trap_o(dbg_trap));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    sa_addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    sa_addr = a; wdata = d; sa_we = 1;
    step();
    sa_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, keep;
    step(); step();
    rst_n = 1;
    step();
    // R12 reset state
    chk("R12 in_smm", {31'b0, in_smm}, 0);
    chk("R12 outs", {22'b0, nmi_mask, ef_we, ef_if, dr_we, restart_io, next_insn, undef, nmi_out, dbg_trap, 1'b0}, 0);
    rd(16'hFFA4, v); chk("R12 trap word", v, 0);
    rd(16'hFF00, v); chk("R12 slot", v, 0);

    for (int s = 0; s < 128; s++) begin
      logic t, va, d, f, nm, b1, rs, ud;
      logic [15:0] slot;
      t = s[0]; va = s[1]; d = s[2]; f = s[3]; nm = s[4];
      case (s[6:5])
        2'd0: slot = 16'h0000;
        2'd1: slot = 16'h00FF;
        2'd2: slot = 16'h00FE;
        default: slot = 16'h01FF;
      endcase
      b1 = t & va;
      rs = (slot == 16'h00FF) && b1;
      ud = (slot == 16'h00FF) && !b1;
      io_trap = t; io_valid = va; dbg = d; ifl = f;
      dr6 = 32'h6000_0000 | s; dr7 = 32'h7000_0000 | s;
      smi = 1;
      step();
      smi = 0; io_trap = 0; io_valid = 0; dbg = 0; ifl = ~f; dr6 = '1; dr7 = '1;
      chk("R1 in_smm", {31'b0, in_smm}, 1);
      chk("R1 nmi_mask", {31'b0, nmi_mask}, 1);
      chk("R1 if write", {30'b0, ef_we, ef_if}, 32'h2);
      chk("R7 no trap at entry", {31'b0, dbg_trap}, 0);
      rd(16'hFFA4, v); chk("R2 trap word", v, {30'b0, b1, t});
      rd(16'hFF00, v); chk("R3 slot cleared", v, 0);
      if (nm) begin
        nmi = 1; step(); nmi = 0;
        chk("R9 nmi held", {31'b0, nmi_out}, 0);
      end
      wr(16'hFF00, {16'hABCD, slot});
      rd(16'hFF00, v); chk("R3 slot write", v, {16'h0, slot});
      chk("R11 still in smm", {31'b0, in_smm}, 1);
      chk("R7 held in smm", {31'b0, dbg_trap}, 0);
      rsm = 1; step(); rsm = 0;
      chk("R11 left smm", {31'b0, in_smm}, 0);
      chk("R4 restart", {31'b0, restart_io}, {31'b0, rs});
      chk("R4 next", {31'b0, next_insn}, {31'b0, !rs});
      chk("R5 undef", {31'b0, undef}, {31'b0, ud});
      chk("R10 dr we", {31'b0, dr_we}, 1);
      chk("R10 dr6", dr6_out, 32'h6000_0000 | s);
      chk("R10 dr7", dr7_out, 32'h7000_0000 | s);
      chk("R10 if restore", {30'b0, ef_we, ef_if}, {30'b0, 1'b1, f});
      chk("R7 trap after resume", {31'b0, dbg_trap}, {31'b0, d && !rs});
      chk("R9 nmi not yet", {31'b0, nmi_out}, 0);
      step();
      chk("R9 nmi released", {31'b0, nmi_out}, {31'b0, nm});
      chk("R10 single pulse", {30'b0, ef_we, dr_we}, 0);
      if (d && rs) begin
        chk("R8 waits for io_done", {31'b0, dbg_trap}, 0);
        step();
        chk("R8 still waiting", {31'b0, dbg_trap}, 0);
        io_done = 1; step(); io_done = 0;
        chk("R8 trap after io_done", {31'b0, dbg_trap}, 1);
        step();
        chk("R8 single pulse", {31'b0, dbg_trap}, 0);
      end
      step();
    end

    // R6 nested entry suppresses validity
    smi = 1; step(); smi = 0;
    smi = 1; step(); smi = 0;
    io_trap = 1; io_valid = 1;
    rsm = 1; step(); rsm = 0;
    chk("R6 resumed", {31'b0, in_smm}, 0);
    chk("R6 next", {31'b0, next_insn}, 1);
    step();
    io_trap = 0; io_valid = 0;
    chk("R6 re-entered", {31'b0, in_smm}, 1);
    rd(16'hFFA4, v); chk("R6 bit1 clear", v, 32'h1);
    rsm = 1; step(); rsm = 0; step();
    chk("R6 no third entry", {31'b0, in_smm}, 0);

    // R3 handler rewrite of trap word drives restart
    io_trap = 1; io_valid = 0; smi = 1; step(); smi = 0; io_trap = 0;
    wr(16'hFFA4, 32'h3);
    wr(16'hFF00, 32'h00FF);
    rd(16'hFFA4, v); chk("R3 trap word write", v, 32'h3);
    rd(16'h1234, v); chk("R3 other address", v, 0);
    rsm = 1; step(); rsm = 0;
    chk("R4 restart via rewrite", {30'b0, restart_io, undef}, 32'h2);
    step();

    // R3 writes outside SMM ignored
    rd(16'hFFA4, keep);
    wr(16'hFFA4, 32'hDEAD_BEEF);
    rd(16'hFFA4, v); chk("R3 outside write ignored", v, keep);
    wr(16'hFF00, 32'h1111);
    rd(16'hFF00, v); chk("R3 outside slot ignored", v, 32'h00FF);

    // R11 resume outside SMM ignored
    rsm = 1; step(); rsm = 0;
    chk("R11 rsm outside", {28'b0, in_smm, restart_io, next_insn, dr_we}, 0);

    // R9 / R7 outside SMM pass through
    nmi = 1; step(); nmi = 0;
    chk("R9 nmi outside", {31'b0, nmi_out}, 1);
    step();
    chk("R9 nmi pulse", {31'b0, nmi_out}, 0);
    dbg = 1; step(); dbg = 0;
    chk("R7 dbg outside", {31'b0, dbg_trap}, 1);
    step();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule